// File: doc/BRIEF.md
# Paged EEPROM Write-Load Controller

This block is the write side of a paged non-volatile memory, placed behind an asynchronous-style parallel bus. The bus has active-low chip enable, output enable and write enable, a 17-bit address and an 8-bit data path. All bus pins reach the block already synchronised to `clk`. A write pulse loads one byte into a page buffer. The first accepted byte fixes the page. Later bytes for the same page may land in any slot, in any order, for as long as each one arrives before the inter-byte gap timer runs out.

When the gap timer expires, the block closes the load window and starts a programming phase of fixed length, during which `busy` is high. At the end of that phase it copies into the behavioural storage array only the slots that were loaded, and clears its record of loaded slots. The pulse-width filter, the gap limit and the programming time are all counted in clock cycles through parameters, so a simulation can use short values.

The storage array holds `ARRAY_PAGES` pages. The low page-address bits select the page, and the higher page bits alias onto it. A read drives the addressed byte straight from the array.

Top module: `eepg_page_ctrl`

## Requirements
- R1: A byte load is recognised when chip enable is low, write enable is low and output enable is high. The load is taken when that condition ends, so either a write-enable pulse with chip enable held low or a chip-enable pulse with write enable held low starts a write.
- R2: While output enable is low, no write condition exists and no byte is loaded, whatever chip enable and write enable do.
- R3: A write condition lasting fewer than `MIN_PULSE` consecutive clock edges loads nothing. A condition lasting `MIN_PULSE` or more edges loads one byte.
- R4: The address is captured on the first edge of the write condition and held unchanged for the rest of it. The data is the value sampled on the last edge of the write condition.
- R5: Take the first rising edge that samples the write condition released after the last accepted byte. `busy` rises on the (`LOAD_WIN`+2)th rising edge counted from that edge, provided no further byte for the page arrives. A byte that does arrive in time restarts the gap.
- R6: The page is address bits 16:7 of the first byte in a window. A later byte whose bits 16:7 differ is ignored and sets `page_err`. `page_err` stays set until the next window opens, and it clears when that window opens.
- R7: The slot is address bits 6:0. Slots may be loaded in any order. Loading the same slot again within one window replaces the earlier byte, so the last byte written to a slot is the one programmed.
- R8: At the end of programming, only slots loaded in that window are written to the array. Every other byte of the page keeps its old value.
- R9: `busy` stays high for exactly `PROG_CYC` rising edges and then falls. The loaded-slot record is empty whenever no window is open.
- R10: Write pulses during programming are ignored. They change no array byte and do not open a new window when programming ends.
- R11: When chip enable is low, output enable is low and write enable is high, `rdata_oe` is 1 and `rdata` shows the array byte at the address, with no clock delay. Otherwise `rdata_oe` is 0 and `rdata` is 0. After reset every array byte reads 8'hFF.
- R12: A single window accepts all 128 slots of a page, and all 128 are programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, synchronised |
| oe_n | input | 1 | Output enable, active low, synchronised |
| we_n | input | 1 | Write enable, active low, synchronised |
| addr | input | 17 | Byte address: page in 16:7, slot in 6:0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| rdata_oe | output | 1 | High while a read drives `rdata` |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | A byte for a foreign page was dropped in the current window |

## Verification
The in-line assertions check, on every cycle, several rules that hold at all times:
- a load is emitted only after the write condition ends, and only once the width count reached its limit;
- the captured address stays stable during a pulse;
- the page stays fixed while a window is open;
- no buffer write happens while `busy` is high;
- `busy` falls only after the full program count;
- the loaded-slot record is empty outside a window.

Only the directed scenarios can show the end-to-end results: the exact cycle on which `busy` rises and falls, last-write-wins on a slot, untouched neighbour bytes, dropped foreign-page bytes, and the blocking of short, output-enabled or busy-time pulses. These show up only as the contents read back from the array through the bus.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 7;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGE_W = ADDR_W - SLOT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;
endpackage

// File: rtl/eepg_strobe_filter.sv
module eepg_strobe_filter
    import eepg_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic              act;
        logic [CW-1:0]     width;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              vld;
    } flt_s;

    flt_s flt_d, flt_q;
    logic wr_cond;

    always_comb begin
        wr_cond   = !ce_n && !we_n && oe_n;
        flt_d     = flt_q;
        flt_d.act = wr_cond;
        flt_d.vld = 1'b0;
        if (wr_cond) begin
            if (!flt_q.act) begin
                flt_d.addr  = addr;
                flt_d.width = CW'(1);
            end else if (flt_q.width != CW'(MIN_PULSE)) begin
                flt_d.width = flt_q.width + CW'(1);
            end
            flt_d.data = wdata;
        end else if (flt_q.act) begin
            flt_d.vld = (flt_q.width == CW'(MIN_PULSE));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign ld_vld  = flt_q.vld;
    assign ld_addr = flt_q.addr;
    assign ld_data = flt_q.data;

    // R1
    load_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.vld |-> !flt_q.act);

    // R3
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.vld |-> (flt_q.width == CW'(MIN_PULSE)));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.act && $past(flt_q.act)) |-> $stable(flt_q.addr));
endmodule

// File: rtl/eepg_page_buf.sv
module eepg_page_buf
    import eepg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clr,
    output logic [SLOTS-1:0]             mask,
    output logic [SLOTS-1:0][DATA_W-1:0] bytes
);
    logic [SLOTS-1:0]             mask_d, mask_q;
    logic [SLOTS-1:0][DATA_W-1:0] byte_d, byte_q;

    always_comb begin
        mask_d = mask_q;
        byte_d = byte_q;
        if (clr) begin
            mask_d = '0;
        end else if (wr_en) begin
            mask_d[wr_slot] = 1'b1;
            byte_d[wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            byte_q <= '0;
        end else begin
            mask_q <= mask_d;
            byte_q <= byte_d;
        end
    end

    assign mask  = mask_q;
    assign bytes = byte_q;

    // R7
    last_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (mask_q[$past(wr_slot)] && byte_q[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/eepg_seq.sv
module eepg_seq
    import eepg_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              buf_we,
    output logic [SLOT_W-1:0] buf_slot,
    output logic [DATA_W-1:0] buf_data,
    output logic              commit,
    output logic [PAGE_W-1:0] commit_page,
    output logic              win_open,
    output logic              busy,
    output logic              page_err
);
    localparam int GW = (LOAD_WIN > 1) ? $clog2(LOAD_WIN) : 1;
    localparam int PW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [GW-1:0]     gap;
        logic [PW-1:0]     pcnt;
        logic              err;
    } seq_s;

    seq_s seq_d, seq_q;
    logic [PAGE_W-1:0] ld_page;

    always_comb begin
        seq_d    = seq_q;
        buf_we   = 1'b0;
        commit   = 1'b0;
        ld_page  = ld_addr[ADDR_W-1:SLOT_W];
        buf_slot = ld_addr[SLOT_W-1:0];
        buf_data = ld_data;
        case (seq_q.state)
            ST_IDLE: begin
                if (ld_vld) begin
                    seq_d.state = ST_LOAD;
                    seq_d.page  = ld_page;
                    seq_d.gap   = '0;
                    seq_d.err   = 1'b0;
                    buf_we      = 1'b1;
                end
            end
            ST_LOAD: begin
                if (ld_vld && ld_page == seq_q.page) begin
                    buf_we    = 1'b1;
                    seq_d.gap = '0;
                end else begin
                    if (ld_vld) seq_d.err = 1'b1;
                    if (seq_q.gap == GW'(LOAD_WIN - 1)) begin
                        seq_d.state = ST_PROG;
                        seq_d.pcnt  = '0;
                    end else begin
                        seq_d.gap = seq_q.gap + GW'(1);
                    end
                end
            end
            ST_PROG: begin
                if (seq_q.pcnt == PW'(PROG_CYC - 1)) begin
                    commit      = 1'b1;
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + PW'(1);
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign commit_page = seq_q.page;
    assign win_open    = (seq_q.state == ST_LOAD);
    assign busy        = (seq_q.state == ST_PROG);
    assign page_err    = seq_q.err;

    // R6
    page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_LOAD && $past(seq_q.state) == ST_LOAD) |-> $stable(seq_q.page));

    // R6
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.err) |-> $past(ld_vld));

    // R5
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(seq_q.gap) == GW'(LOAD_WIN - 1) && !$past(ld_vld)));

    // R9
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(seq_q.pcnt) == PW'(PROG_CYC - 1)));

    // R10
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);
endmodule

// File: rtl/eepg_array.sv
module eepg_array
    import eepg_pkg::*;
#(
    parameter int ARRAY_PAGES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [$clog2(ARRAY_PAGES)-1:0] commit_page,
    input  logic [SLOTS-1:0]             mask,
    input  logic [SLOTS-1:0][DATA_W-1:0] bytes,
    input  logic [$clog2(ARRAY_PAGES)+SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int PB    = $clog2(ARRAY_PAGES);
    localparam int DEPTH = ARRAY_PAGES * SLOTS;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    for (genvar gp = 0; gp < ARRAY_PAGES; gp++) begin : g_page
        for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
            logic hit_d;
            assign hit_d = commit && (commit_page == PB'(gp)) && mask[gs];
            always_ff @(posedge clk) begin
                if (!rst_n)     mem_q[gp*SLOTS+gs] <= '1;
                else if (hit_d) mem_q[gp*SLOTS+gs] <= bytes[gs];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/eepg_page_ctrl.sv
module eepg_page_ctrl
    import eepg_pkg::*;
#(
    parameter int MIN_PULSE   = 3,
    parameter int LOAD_WIN    = 7500,
    parameter int PROG_CYC    = 500000,
    parameter int ARRAY_PAGES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [16:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        rdata_oe,
    output logic        busy,
    output logic        page_err
);
    localparam int PB = $clog2(ARRAY_PAGES);

    logic                         ld_vld;
    logic [ADDR_W-1:0]            ld_addr;
    logic [DATA_W-1:0]            ld_data;
    logic                         buf_we, buf_clr, win_open;
    logic [SLOT_W-1:0]            buf_slot;
    logic [DATA_W-1:0]            buf_data;
    logic [PAGE_W-1:0]            commit_page;
    logic [SLOTS-1:0]             slot_mask;
    logic [SLOTS-1:0][DATA_W-1:0] slot_bytes;
    logic [DATA_W-1:0]            arr_data;

    eepg_strobe_filter #(.MIN_PULSE(MIN_PULSE)) i_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    eepg_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
        .buf_we(buf_we), .buf_slot(buf_slot), .buf_data(buf_data),
        .commit(buf_clr), .commit_page(commit_page), .win_open(win_open),
        .busy(busy), .page_err(page_err)
    );

    eepg_page_buf i_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_we), .wr_slot(buf_slot), .wr_data(buf_data), .clr(buf_clr),
        .mask(slot_mask), .bytes(slot_bytes)
    );

    eepg_array #(.ARRAY_PAGES(ARRAY_PAGES)) i_array (
        .clk(clk), .rst_n(rst_n),
        .commit(buf_clr), .commit_page(commit_page[PB-1:0]),
        .mask(slot_mask), .bytes(slot_bytes),
        .rd_idx(addr[PB+SLOT_W-1:0]), .rd_data(arr_data)
    );

    assign rdata_oe = !ce_n && !oe_n && we_n;
    assign rdata    = rdata_oe ? arr_data : '0;

    // R9
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !busy) |-> (slot_mask == '0));

    // R10
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(slot_mask) || slot_mask == '0));
endmodule

// File: tb/test_eepg_page_ctrl.sv
module test_eepg_page_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MINP = 3;
    localparam int WIN  = 20;
    localparam int PRG  = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe, busy, page_err;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    eepg_page_ctrl #(.MIN_PULSE(MINP), .LOAD_WIN(WIN), .PROG_CYC(PRG), .ARRAY_PAGES(4)) i_eepg_page_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .busy(busy), .page_err(page_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] pa(input int page, input int slot);
        return 17'((page << 7) | slot);
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 0: write-enable pulse with chip enable low; mode 1: chip-enable pulse with write enable low
    task automatic wr(input logic [16:0] a, input logic [7:0] d, input int p, input bit mode, input logic oe);
        @(negedge clk);
        addr = a; wdata = d; oe_n = oe;
        if (mode) begin
            we_n = 1'b0;
            @(negedge clk);
            ce_n = 1'b0;
        end else begin
            ce_n = 1'b0; we_n = 1'b0;
        end
        repeat (p) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic oe_flag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = rdata; oe_flag = rdata_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [16:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       f;
        rd(a, d, f);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic       f;
        check("R9 busy after reset", {31'd0, busy}, 32'd0);
        check("R6 page_err after reset", {31'd0, page_err}, 32'd0);
        check("R11 rdata_oe idle", {31'd0, rdata_oe}, 32'd0);
        rd(pa(2, 40), d, f);
        check("R11 erased byte", {24'd0, d}, 32'hFF);
        check("R11 rdata_oe on read", {31'd0, f}, 32'd1);
    endtask

    task automatic t_single_timing();
        wr(pa(1, 5), 8'hA5, MINP, 1'b0, 1'b1);
        waitn(WIN + 1);
        check("R5 busy still low before window end", {31'd0, busy}, 32'd0);
        waitn(1);
        check("R5 busy rises at window end", {31'd0, busy}, 32'd1);
        waitn(PRG - 1);
        check("R9 busy held for program time", {31'd0, busy}, 32'd1);
        waitn(1);
        check("R9 busy falls after program time", {31'd0, busy}, 32'd0);
        rd_chk("R1 byte programmed", pa(1, 5), 8'hA5);
        rd_chk("R8 unloaded neighbour", pa(1, 6), 8'hFF);
    endtask

    task automatic t_order_overwrite();
        wr(pa(2, 9), 8'h11, MINP, 1'b0, 1'b1);
        wr(pa(2, 3), 8'h33, MINP, 1'b0, 1'b1);
        wr(pa(2, 9), 8'h99, MINP + 2, 1'b0, 1'b1);
        waitn(WIN + PRG + 5);
        rd_chk("R7 overwritten slot keeps last", pa(2, 9), 8'h99);
        rd_chk("R7 out-of-order slot", pa(2, 3), 8'h33);
        rd_chk("R8 unloaded slot", pa(2, 8), 8'hFF);
        wr(pa(2, 3), 8'h44, MINP, 1'b0, 1'b1);
        waitn(WIN + PRG + 5);
        rd_chk("R8 reprogrammed slot", pa(2, 3), 8'h44);
        rd_chk("R8 earlier slot untouched", pa(2, 9), 8'h99);
    endtask

    task automatic t_gap_restart();
        wr(pa(1, 20), 8'h20, MINP, 1'b0, 1'b1);
        waitn(WIN - 4);
        wr(pa(1, 21), 8'h21, MINP, 1'b0, 1'b1);
        waitn(WIN + 1);
        check("R5 late byte restarts gap", {31'd0, busy}, 32'd0);
        waitn(1);
        check("R5 busy after restarted gap", {31'd0, busy}, 32'd1);
        waitn(PRG + 3);
        rd_chk("R5 first byte of stretched window", pa(1, 20), 8'h20);
        rd_chk("R5 second byte of stretched window", pa(1, 21), 8'h21);
    endtask

    task automatic t_short_pulse();
        wr(pa(0, 0), 8'h12, MINP - 1, 1'b0, 1'b1);
        waitn(WIN + 5);
        check("R3 short pulse opens no window", {31'd0, busy}, 32'd0);
        rd_chk("R3 short pulse writes nothing", pa(0, 0), 8'hFF);
    endtask

    task automatic t_oe_inhibit();
        wr(pa(0, 1), 8'h34, MINP + 2, 1'b0, 1'b0);
        waitn(WIN + 5);
        check("R2 output enable low blocks write", {31'd0, busy}, 32'd0);
        rd_chk("R2 inhibited byte not written", pa(0, 1), 8'hFF);
    endtask

    task automatic t_ce_controlled();
        wr(pa(3, 127), 8'h5C, MINP, 1'b1, 1'b1);
        waitn(WIN + PRG + 5);
        rd_chk("R1 chip-enable controlled write", pa(3, 127), 8'h5C);
    endtask

    task automatic t_page_violation();
        wr(pa(1, 10), 8'h77, MINP, 1'b0, 1'b1);
        wr(pa(0, 10), 8'h66, MINP, 1'b0, 1'b1);
        waitn(2);
        check("R6 foreign page flags error", {31'd0, page_err}, 32'd1);
        waitn(WIN + PRG + 5);
        rd_chk("R6 first-page byte programmed", pa(1, 10), 8'h77);
        rd_chk("R6 foreign byte dropped", pa(0, 10), 8'hFF);
        check("R6 error held until next window", {31'd0, page_err}, 32'd1);
        wr(pa(3, 0), 8'h01, MINP, 1'b0, 1'b1);
        waitn(2);
        check("R6 error cleared by new window", {31'd0, page_err}, 32'd0);
    endtask

    // continues the window opened at the end of t_page_violation
    task automatic t_busy_ignore();
        waitn(WIN + 1);
        check("R9 busy during program", {31'd0, busy}, 32'd1);
        wr(pa(3, 1), 8'h02, MINP, 1'b0, 1'b1);
        waitn(PRG + 2);
        check("R9 program finished", {31'd0, busy}, 32'd0);
        waitn(WIN + 4);
        check("R10 ignored write opens no window", {31'd0, busy}, 32'd0);
        rd_chk("R10 byte loaded before busy", pa(3, 0), 8'h01);
        rd_chk("R10 busy-time byte dropped", pa(3, 1), 8'hFF);
    endtask

    task automatic t_full_page();
        for (int s = 0; s < 128; s++) wr(pa(0, s), 8'(s) ^ 8'h5A, MINP, 1'b0, 1'b1);
        waitn(WIN + PRG + 5);
        for (int s = 0; s < 128; s++) rd_chk("R12 full page slot", pa(0, s), 8'(s) ^ 8'h5A);
    endtask

    initial begin
        waitn(4);
        rst_n = 1'b1;
        waitn(1);
        t_reset();
        t_single_timing();
        t_order_overwrite();
        t_gap_restart();
        t_short_pulse();
        t_oe_inhibit();
        t_ce_controlled();
        t_page_violation();
        t_busy_ignore();
        t_full_page();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule